// File: doc/BRIEF.md
# Modulator Input Conditioner

This block sits between an upsampling filter and a sigma-delta modulator. It registers each incoming signed sample and scales it on the way through. It also provides a mute. A headroom control halves the sample to leave margin for intersample overs. A debug control multiplies it by four so that overload behaviour can be studied. Both controls can be active at once: the sample is halved first and then multiplied by four, for a net gain of two. The scaled result saturates to the output word width and never wraps.

The modulator's integrators each raise a clip flag when they limit. The block holds a single clip indicator high for a fixed window after the last cycle in which any flag was set, and each new flag restarts that window. The default window is 2^24 master-clock cycles. On a 19 to 25 MHz master clock that is somewhat under one second, which is long enough to drive a visible lamp or to be polled. Mute silences the sample path only and leaves a running clip indication alone.

Top module: `mod_input_conditioner`

## Requirements
- R1: While rst_ni is low, sample_o is 0 and clip_o is 0.
- R2: With gain_up_i=0 and headroom_n_i=1, a cycle with valid_i=1 and mute_i=0 puts sample_i on sample_o, sign-extended, after the next rising clock edge.
- R3: With headroom_n_i=0 and gain_up_i=0, the loaded value is sample_i arithmetically shifted right by one, which rounds toward minus infinity (-3 gives -2 and -1 gives -1).
- R4: With gain_up_i=1 and headroom_n_i=1, the loaded value is sample_i times 4, saturated to the signed OUT_W range.
- R5: With gain_up_i=1 and headroom_n_i=0, the loaded value is (sample_i arithmetically shifted right by one) times 4, saturated to the signed OUT_W range (-3 gives -8, 3 gives 4).
- R6: In a cycle with valid_i=0 and mute_i=0, sample_o keeps its value after the next edge.
- R7: In any cycle with mute_i=1, sample_o is 0 after the next edge, whatever valid_i is.
- R8: If any bit of clip_flags_i is high in a cycle, clip_o is high after the next edge. It stays high until 2^STRETCH_W-1 edges have passed with all flags low, and then it drops.
- R9: mute_i has no effect on clip_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | IN_W | Signed input sample |
| valid_i | input | 1 | Sample strobe |
| gain_up_i | input | 1 | 1 = multiply by 4 (debug gain) |
| headroom_n_i | input | 1 | 0 = halve (headroom) |
| mute_i | input | 1 | 1 = force the output sample to zero |
| clip_flags_i | input | N_INT | Integrator clip flags, one per integrator |
| sample_o | output | OUT_W | Scaled, saturated signed sample |
| clip_o | output | 1 | Stretched clip indicator |

## Verification
A wrong gain mode or a wrong shift direction appears on sample_o one edge after the strobe. Corner values such as -3, the most negative code, and inputs just past the saturation points make rounding and clamping errors visible at once. A stale or miscounted hold counter shows up only at the end of the window, as clip_o dropping one or more cycles early or late. It can also show up when a retrigger in mid-window fails to extend the pulse, so the bench runs complete windows with a shortened counter. Interaction faults, such as mute clearing the clip hold or a sample loading while muted, show up on the first edge after the conflicting inputs.

// File: rtl/modin_pkg.sv
package modin_pkg;
  // {gain_up, ~headroom_n}
  typedef enum logic [1:0] {
    GAIN_UNITY  = 2'b00,
    GAIN_HALF   = 2'b01,
    GAIN_QUAD   = 2'b10,
    GAIN_DOUBLE = 2'b11
  } gain_mode_e;
endpackage

// File: rtl/mod_gain_stage.sv
module mod_gain_stage
  import modin_pkg::*;
#(
  parameter int IN_W  = 24,
  parameter int OUT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IN_W-1:0]  sample_i,
  input  logic             valid_i,
  input  gain_mode_e       mode_i,
  input  logic             mute_i,
  output logic [OUT_W-1:0] sample_o
);
  localparam int BASE_W = (IN_W > OUT_W) ? IN_W : OUT_W;
  localparam int EXT_W  = BASE_W + 3;
  localparam logic signed [EXT_W-1:0] SAT_MAX =
    {{(EXT_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [EXT_W-1:0] SAT_MIN =
    {{(EXT_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  logic signed [EXT_W-1:0] ext;
  logic signed [EXT_W-1:0] scaled;
  logic        [OUT_W-1:0] sat;
  logic        [OUT_W-1:0] sample_q;

  assign ext = {{(EXT_W-IN_W){sample_i[IN_W-1]}}, sample_i};

  // halve before gain so both apply as net x2
  always_comb begin
    unique case (mode_i)
      GAIN_HALF:   scaled = ext >>> 1;
      GAIN_QUAD:   scaled = ext <<< 2;
      GAIN_DOUBLE: scaled = (ext >>> 1) <<< 2;
      default:     scaled = ext;
    endcase
  end

  always_comb begin
    if (scaled > SAT_MAX)      sat = SAT_MAX[OUT_W-1:0];
    else if (scaled < SAT_MIN) sat = SAT_MIN[OUT_W-1:0];
    else                       sat = scaled[OUT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sample_q <= '0;
    else if (mute_i)  sample_q <= '0;
    else if (valid_i) sample_q <= sat;
  end

  assign sample_o = sample_q;
endmodule

// File: rtl/clip_stretcher.sv
module clip_stretcher #(
  parameter int N_FLAGS = 5,
  parameter int CNT_W   = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_FLAGS-1:0] flags_i,
  output logic               clip_o
);
  logic             any_clip;
  logic [CNT_W-1:0] hold_q;

  assign any_clip = |flags_i;

  // retrigger reloads the full window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              hold_q <= '0;
    else if (any_clip)        hold_q <= '1;
    else if (hold_q != '0)    hold_q <= hold_q - 1'b1;
  end

  assign clip_o = (hold_q != '0);
endmodule

// File: rtl/mod_input_conditioner.sv
module mod_input_conditioner
  import modin_pkg::*;
#(
  parameter int IN_W      = 24,
  parameter int OUT_W     = 24,
  parameter int N_INT     = 5,
  parameter int STRETCH_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IN_W-1:0]  sample_i,
  input  logic             valid_i,
  input  logic             gain_up_i,
  input  logic             headroom_n_i,
  input  logic             mute_i,
  input  logic [N_INT-1:0] clip_flags_i,
  output logic [OUT_W-1:0] sample_o,
  output logic             clip_o
);
  gain_mode_e mode;

  assign mode = gain_mode_e'({gain_up_i, ~headroom_n_i});

  mod_gain_stage #(
    .IN_W (IN_W),
    .OUT_W(OUT_W)
  ) u_gain (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sample_i(sample_i),
    .valid_i (valid_i),
    .mode_i  (mode),
    .mute_i  (mute_i),
    .sample_o(sample_o)
  );

  clip_stretcher #(
    .N_FLAGS(N_INT),
    .CNT_W  (STRETCH_W)
  ) u_clip (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flags_i(clip_flags_i),
    .clip_o (clip_o)
  );
endmodule

// File: rtl/mod_input_conditioner_chk.sv
module mod_input_conditioner_chk #(
  parameter int IN_W      = 24,
  parameter int OUT_W     = 24,
  parameter int N_INT     = 5,
  parameter int STRETCH_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [IN_W-1:0]  sample_i,
  input logic             valid_i,
  input logic             gain_up_i,
  input logic             headroom_n_i,
  input logic             mute_i,
  input logic [N_INT-1:0] clip_flags_i,
  input logic [OUT_W-1:0] sample_o,
  input logic             clip_o
);
  logic [STRETCH_W:0] quiet_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               quiet_run <= '0;
    else if (|clip_flags_i)    quiet_run <= '0;
    else if (clip_o)           quiet_run <= quiet_run + 1'b1;
    else                       quiet_run <= '0;
  end

  AST_MUTE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mute_i |=> sample_o == '0); // R7

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i && !mute_i |=> $stable(sample_o)); // R6

  AST_CLIP_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |clip_flags_i |=> clip_o); // R8

  AST_CLIP_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quiet_run < {1'b1, {STRETCH_W{1'b0}}}); // R8

  generate
    if (OUT_W >= IN_W) begin : g_pass
      AST_UNITY_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i && !mute_i && !gain_up_i && headroom_n_i
        |=> $signed(sample_o) == $signed($past(sample_i))); // R2
    end
  endgenerate
endmodule

bind mod_input_conditioner mod_input_conditioner_chk #(
  .IN_W(IN_W), .OUT_W(OUT_W), .N_INT(N_INT), .STRETCH_W(STRETCH_W)
) u_chk (.*);

// File: tb/mod_input_conditioner_tb.sv
module mod_input_conditioner_tb;
  localparam int IN_W  = 16;
  localparam int OUT_W = 16;
  localparam int N_INT = 5;
  localparam int SW    = 6;
  localparam int HOLD  = (1 << SW) - 1;
  localparam int OMAX  = (1 << (OUT_W-1)) - 1;
  localparam int OMIN  = -(1 << (OUT_W-1));

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [IN_W-1:0]  sample_in = '0;
  logic             valid = 1'b0;
  logic             gain_up = 1'b0;
  logic             hr_n = 1'b1;
  logic             mute = 1'b0;
  logic [N_INT-1:0] flags = '0;
  logic [OUT_W-1:0] sample_out;
  logic             clip;

  int    errors = 0, checks = 0, cycles = 0;
  int    exp_sample = 0, exp_cnt = 0, v;
  string exp_tag = "R1", phase_tag = "R2", clip_tag = "R8";

  always #4 clk = ~clk;

  mod_input_conditioner #(
    .IN_W(IN_W), .OUT_W(OUT_W), .N_INT(N_INT), .STRETCH_W(SW)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(sample_in), .valid_i(valid),
    .gain_up_i(gain_up), .headroom_n_i(hr_n), .mute_i(mute),
    .clip_flags_i(flags), .sample_o(sample_out), .clip_o(clip)
  );

  // behavioural reference, advanced on each edge
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      exp_sample = 0; exp_cnt = 0; exp_tag = "R1";
    end else begin
      if (mute) begin
        exp_sample = 0; exp_tag = "R7";
      end else if (valid) begin
        v = int'($signed(sample_in));
        if (!hr_n) v = v >>> 1;
        if (gain_up) v = v * 4;
        if (v > OMAX) v = OMAX;
        if (v < OMIN) v = OMIN;
        exp_sample = v; exp_tag = phase_tag;
      end else begin
        exp_tag = "R6";
      end
      if (|flags) exp_cnt = HOLD;
      else if (exp_cnt > 0) exp_cnt--;
    end
    if (cycles > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog: cycles=%0d expected below 20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic compare();
    int    act;
    string ct;
    act = int'($signed(sample_out));
    ct  = rst_n ? clip_tag : "R1";
    checks++;
    if (act != exp_sample) begin
      errors++;
      $display("FAIL %s sample_o: actual=%0d expected=%0d", exp_tag, act, exp_sample);
    end
    checks++;
    if (clip !== (exp_cnt > 0)) begin
      errors++;
      $display("FAIL %s clip_o: actual=%0b expected=%0b", ct, clip, exp_cnt > 0);
    end
  endtask

  task automatic cyc(input logic [IN_W-1:0] s, input bit vl, input bit g,
                     input bit h, input bit m, input logic [N_INT-1:0] f);
    sample_in = s; valid = vl; gain_up = g; hr_n = h; mute = m; flags = f;
    @(negedge clk);
    compare();
  endtask

  task automatic idle(input int n, input bit m);
    for (int i = 0; i < n; i++) cyc(16'($urandom), 1'b0, 1'b0, 1'b1, m, '0);
  endtask

  initial begin
    // R1 reset state
    for (int i = 0; i < 3; i++) cyc(16'h1234, 1'b1, 1'b0, 1'b1, 1'b0, 5'b00001);
    rst_n = 1'b1;

    phase_tag = "R2";
    for (int i = 0; i < 24; i++)
      cyc(16'($urandom), $urandom_range(0, 3) != 0, 1'b0, 1'b1, 1'b0, '0);
    cyc(16'h8000, 1'b1, 1'b0, 1'b1, 1'b0, '0);
    cyc(16'h7FFF, 1'b1, 1'b0, 1'b1, 1'b0, '0);

    phase_tag = "R3";
    cyc(16'hFFFD, 1'b1, 1'b0, 1'b0, 1'b0, '0); // -3 -> -2
    cyc(16'h0003, 1'b1, 1'b0, 1'b0, 1'b0, '0);
    cyc(16'hFFFF, 1'b1, 1'b0, 1'b0, 1'b0, '0); // -1 -> -1
    for (int i = 0; i < 16; i++)
      cyc(16'($urandom), $urandom_range(0, 3) != 0, 1'b0, 1'b0, 1'b0, '0);

    phase_tag = "R4";
    cyc(16'h2000, 1'b1, 1'b1, 1'b1, 1'b0, '0); // saturate high
    cyc(16'hE000, 1'b1, 1'b1, 1'b1, 1'b0, '0); // exact min
    cyc(16'hDFFF, 1'b1, 1'b1, 1'b1, 1'b0, '0); // saturate low
    cyc(16'h1FFF, 1'b1, 1'b1, 1'b1, 1'b0, '0);
    for (int i = 0; i < 16; i++)
      cyc(16'($urandom), 1'b1, 1'b1, 1'b1, 1'b0, '0);

    phase_tag = "R5";
    cyc(16'hFFFD, 1'b1, 1'b1, 1'b0, 1'b0, '0); // -3 -> -8
    cyc(16'h0003, 1'b1, 1'b1, 1'b0, 1'b0, '0); // 3 -> 4
    cyc(16'h4000, 1'b1, 1'b1, 1'b0, 1'b0, '0); // saturate high
    cyc(16'h8000, 1'b1, 1'b1, 1'b0, 1'b0, '0); // saturate low
    for (int i = 0; i < 16; i++)
      cyc(16'($urandom), 1'b1, 1'b1, 1'b0, 1'b0, '0);

    // R6 hold and R7 mute mixed with strobes
    phase_tag = "R2";
    cyc(16'h0555, 1'b1, 1'b0, 1'b1, 1'b0, '0);
    idle(4, 1'b0);
    cyc(16'h0777, 1'b1, 1'b0, 1'b1, 1'b1, '0);
    cyc(16'h0123, 1'b0, 1'b0, 1'b1, 1'b1, '0);
    cyc(16'h0321, 1'b1, 1'b0, 1'b1, 1'b0, '0);
    for (int i = 0; i < 20; i++)
      cyc(16'($urandom), $urandom_range(0, 1) != 0, $urandom_range(0, 1) != 0,
          $urandom_range(0, 1) != 0, $urandom_range(0, 3) == 0, '0);

    // R8 single event, full window
    clip_tag = "R8";
    cyc(16'h0, 1'b0, 1'b0, 1'b1, 1'b0, 5'b00100);
    idle(HOLD + 5, 1'b0);
    // R8 retrigger mid-window, then several flags at once
    cyc(16'h0, 1'b0, 1'b0, 1'b1, 1'b0, 5'b00001);
    idle(30, 1'b0);
    cyc(16'h0, 1'b0, 1'b0, 1'b1, 1'b0, 5'b10001);
    cyc(16'h0, 1'b0, 1'b0, 1'b1, 1'b0, 5'b01000);
    idle(HOLD + 5, 1'b0);

    // R9 mute during clip hold
    clip_tag = "R9";
    cyc(16'h0100, 1'b1, 1'b0, 1'b1, 1'b0, 5'b00010);
    idle(10, 1'b1);
    cyc(16'h0100, 1'b1, 1'b0, 1'b1, 1'b1, 5'b00010);
    for (int i = 0; i < HOLD + 5; i++)
      cyc(16'($urandom), 1'b1, 1'b0, 1'b1, i[2], '0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule